// File: doc/BRIEF.md
# Priority Memory Resource Manager

This block lets several client ports share one synchronous memory, strictly one access at a time. A client raises its token request and waits for its grant. Only while it holds the grant does it present a command: a write flag, an address and, for a write, the data. It then waits for a completion pulse. The manager performs the access on its internal memory and returns read data alongside the completion pulse. In the cycle after completion it withdraws the grant, so the next waiting client can enter.

When several clients ask for the token at once, client 0 has the highest priority and the highest index has the lowest. Command traffic from a client that does not hold the grant never reaches the memory, and it is flagged on a per-client error line. The controller steps through idle, grant, wait-for-command, access and completion, then returns to idle. Client count, address width and data width are parameters.

Top module: `shared_mem_mgr`

## Requirements
- R1: When the manager is idle and one or more `tok_req` bits are high at a clock edge, the grant appears after that edge on the lowest-indexed requesting client.
- R2: At most one bit of `tok_gnt` is high in any cycle.
- R3: The holder's command is taken from its own slices: `cmd_wr[i]=1` means write and `0` means read, the address is `cmd_addr[i*AW +: AW]` and the write data is `cmd_wdata[i*DW +: DW]`.
- R4: If a client raises `cmd_valid` in the first cycle its grant is visible, its `done` bit is high in the third cycle after that. The pulse lasts exactly one cycle.
- R5: `rdata` is valid in the cycle `done` is high. For a read it equals the value most recently written to that address.
- R6: The grant stays high through the `done` cycle and is low in the following cycle. A client still requesting then receives the grant one cycle later.
- R7: A command with `cmd_valid[i]` high while client i does not hold the grant leaves the memory unchanged, and `err[i]` is high in that same cycle.
- R8: While reset is active, `tok_gnt`, `done` and `err` are all zero.
- R9: Every address from 0 up to 2^AW-1 can be written and read back independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_req | input | NCLI | Per-client token request, held until completion |
| tok_gnt | output | NCLI | One-hot access grant |
| cmd_valid | input | NCLI | Per-client command present |
| cmd_wr | input | NCLI | Per-client operation, 1 = write |
| cmd_addr | input | NCLI*AW | Packed per-client addresses |
| cmd_wdata | input | NCLI*DW | Packed per-client write data |
| done | output | NCLI | One-cycle completion pulse to the holder |
| rdata | output | DW | Read data, valid with `done` |
| err | output | NCLI | Command seen from a client without the grant |

## Verification
The assertions assume that clients follow the token protocol. A client keeps `tok_req` high until it sees `done`, raises `cmd_valid` only after its grant is visible, and keeps the command steady until completion. The stimulus tasks enforce this by waiting on `tok_gnt` before driving a command and by dropping the request and command together right after `done`. The single deliberate breach is the error case. There a client presents a write with no grant while the manager is idle, and the bench confirms through a later read that the memory is unchanged.

// File: rtl/shared_mem_mgr.sv
module shared_mem_mgr #(
  parameter int NCLI = 4,
  parameter int AW   = 6,
  parameter int DW   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCLI-1:0]   tok_req,
  output logic [NCLI-1:0]   tok_gnt,
  input  logic [NCLI-1:0]   cmd_valid,
  input  logic [NCLI-1:0]   cmd_wr,
  input  logic [NCLI*AW-1:0] cmd_addr,
  input  logic [NCLI*DW-1:0] cmd_wdata,
  output logic [NCLI-1:0]   done,
  output logic [DW-1:0]     rdata,
  output logic [NCLI-1:0]   err
);

  localparam int IW    = (NCLI > 1) ? $clog2(NCLI) : 1;
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {IDLE, GRANT, WAIT_REQ, ACCESS, DONE} st_t;

  st_t            st;
  logic [IW-1:0]  own;
  logic [IW-1:0]  win;
  logic           op_wr;
  logic [AW-1:0]  op_a;
  logic [DW-1:0]  op_d;
  logic [DW-1:0]  rd_q;
  logic [DW-1:0]  mem [DEPTH];

  always_comb begin
    win = '0;
    for (int i = NCLI - 1; i >= 0; i--)
      if (tok_req[i]) win = IW'(i);
  end

  assign tok_gnt = (st != IDLE) ? (NCLI'(1) << own) : '0;
  assign done    = (st == DONE) ? (NCLI'(1) << own) : '0;
  assign err     = cmd_valid & ~tok_gnt;
  assign rdata   = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      own   <= '0;
      op_wr <= 1'b0;
      op_a  <= '0;
      op_d  <= '0;
    end else begin
      case (st)
        IDLE:     if (|tok_req) begin own <= win; st <= GRANT; end
        GRANT:    st <= WAIT_REQ;
        WAIT_REQ: if (cmd_valid[own]) begin
                    op_wr <= cmd_wr[own];
                    op_a  <= cmd_addr[own*AW +: AW];
                    op_d  <= cmd_wdata[own*DW +: DW];
                    st    <= ACCESS;
                  end
        ACCESS:   st <= DONE;
        DONE:     st <= IDLE;
        default:  st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == ACCESS) begin
      if (op_wr) mem[op_a] <= op_d;
      rd_q <= mem[op_a];
    end
  end

  a_r1_prio_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && |tok_req) |=> tok_gnt == $past(tok_req & (~tok_req + NCLI'(1))));

  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tok_gnt));

  a_r3_cmd_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ACCESS) |-> $past(st == WAIT_REQ && (cmd_valid & tok_gnt) != '0));

  a_r4_done_once: assert property (@(posedge clk) disable iff (!rst_n)
    (|done) |=> done == '0);

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (|done) |=> tok_gnt == '0);

endmodule

// File: tb/sim_shared_mem_mgr.sv
module sim_shared_mem_mgr;
  localparam int N = 4, AW = 6, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] tok_req = '0, cmd_valid = '0, cmd_wr = '0;
  logic [N*AW-1:0] cmd_addr = '0;
  logic [N*DW-1:0] cmd_wdata = '0;
  logic [N-1:0] tok_gnt, done, err;
  logic [DW-1:0] rdata;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  shared_mem_mgr #(.NCLI(N), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .tok_req(tok_req), .tok_gnt(tok_gnt),
    .cmd_valid(cmd_valid), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .done(done), .rdata(rdata), .err(err));

  // fields: client[24:23] wr[22] addr[21:16] data[15:0]
  localparam logic [24:0] VEC [10] = '{
    {2'd0, 1'b1, 6'd5,  16'h1111},
    {2'd1, 1'b1, 6'd10, 16'h2222},
    {2'd2, 1'b1, 6'd63, 16'hBEEF},
    {2'd3, 1'b1, 6'd0,  16'h0F0F},
    {2'd3, 1'b0, 6'd5,  16'h1111},
    {2'd0, 1'b0, 6'd63, 16'hBEEF},
    {2'd2, 1'b0, 6'd10, 16'h2222},
    {2'd1, 1'b0, 6'd0,  16'h0F0F},
    {2'd1, 1'b1, 6'd5,  16'hABCD},
    {2'd2, 1'b0, 6'd5,  16'hABCD}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input int c, input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic [DW-1:0] q, output int lat);
    cmd_valid[c] = 1'b1;
    cmd_wr[c] = w;
    cmd_addr[c*AW +: AW] = a;
    cmd_wdata[c*DW +: DW] = d;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!done[c] && lat < 20);
    q = rdata;
    tok_req[c] = 1'b0;
    cmd_valid[c] = 1'b0;
  endtask

  task automatic access(input int c, input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] q, output int lat);
    tok_req[c] = 1'b1;
    @(negedge clk);
    while (!tok_gnt[c]) @(negedge clk);
    send_cmd(c, w, a, d, q, lat);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] q;
    int lat;
    repeat (3) @(negedge clk);
    chk(tok_gnt == '0 && done == '0 && err == '0, "R8 reset", {tok_gnt, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 10; k++) begin
      access(int'(VEC[k][24:23]), VEC[k][22], VEC[k][21:16], VEC[k][15:0], q, lat);
      chk(lat == 3, "R4 latency", lat, 3);
      if (!VEC[k][22]) chk(q == VEC[k][15:0], "R5 R3 R9 read data", q, VEC[k][15:0]);
      @(negedge clk);
      chk(done == '0, "R4 single pulse", done, 0);
      chk(tok_gnt == '0, "R6 release", tok_gnt, 0);
    end

    tok_req[1] = 1'b1; tok_req[3] = 1'b1;
    @(negedge clk);
    chk(tok_gnt == 4'b0010, "R1 priority", tok_gnt, 4'b0010);
    chk($countones(tok_gnt) == 1, "R2 one grant", tok_gnt, 4'b0010);
    send_cmd(1, 1'b0, 6'd10, 16'h0, q, lat);
    chk(q == 16'h2222, "R5 read data", q, 16'h2222);
    @(negedge clk);
    chk(tok_gnt == '0, "R6 release after done", tok_gnt, 0);
    @(negedge clk);
    chk(tok_gnt == 4'b1000, "R6 next client granted", tok_gnt, 4'b1000);
    send_cmd(3, 1'b0, 6'd63, 16'h0, q, lat);
    chk(q == 16'hBEEF, "R9 top address", q, 16'hBEEF);
    @(negedge clk);
    @(negedge clk);

    cmd_valid[2] = 1'b1; cmd_wr[2] = 1'b1;
    cmd_addr[2*AW +: AW] = 6'd5; cmd_wdata[2*DW +: DW] = 16'h0000;
    #1;
    chk(err == 4'b0100, "R7 error flag", err, 4'b0100);
    @(negedge clk);
    cmd_valid[2] = 1'b0; cmd_wr[2] = 1'b0;
    #1;
    chk(err == '0, "R7 error clears", err, 0);
    access(0, 1'b0, 6'd5, 16'h0, q, lat);
    chk(q == 16'hABCD, "R7 memory untouched", q, 16'hABCD);
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule